// File: doc/BRIEF.md
# Multi-Access Read-Modify-Write Register Array

This block holds a small array of registers. A pipeline stage can change several of them for each request it handles. Each request carries three command slots, and each slot holds an opcode, an index and an operand. Slot 0 is the immediate command. It runs in the request cycle and its result comes back one cycle later. Slots 1 and 2 are deferred commands. They go into a small pending queue, and the queue is emptied one command per cycle, only in cycles with no request.

An immediate command that reads an index with updates still waiting in the queue sees the value with those updates already applied. It also takes over those updates, so they are not applied to the memory a second time. When the queue cannot take a deferred command, that command is discarded and a drop counter is incremented.

When requests are spaced far enough apart, all three commands of a request finish before the next request arrives. Under back-to-back traffic, only the immediate command is guaranteed to finish in its own cycle.

Top module: `rmw_array`

## Requirements
- R1: After reset, every register reads 0, `respValid` is 0, `queueFull` is 0 and `dropCount` is 0.
- R2: The opcode encoding is 0 = no operation, 1 = read only, 2 = add the operand (the sum wraps modulo 2^DATA_W), and 3 = overwrite with the operand.
- R3: `respValid` is high exactly one cycle after each cycle with `reqValid` high, and never otherwise. `respData` is the slot 0 register value before slot 0's operation is applied.
- R4: Slot 1 and slot 2 commands whose opcode is not 0 are queued in that order. Slot 1 comes first, and every queued command follows all commands already pending. Slots with opcode 0 take no queue space.
- R5: Immediate commands always get the memory port. A queued command runs only in a cycle with `reqValid` low. One command runs per such cycle, and the oldest runs first.
- R6: A slot 0 command sees every pending queued update to its index, applied in queue order. Those pending updates are absorbed and are not applied to the memory again later.
- R7: `queueFull` is high while QDEPTH commands are pending. Each deferred command that finds no room is discarded, and `dropCount` increases by one for it.
- R8: If the queue is empty when a request arrives and two idle cycles follow, all three of that request's commands have taken effect by the end of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqOp | input | 3x2 | Opcode for each slot; slot 0 is immediate |
| reqIdx | input | 3xIDX_W | Register index for each slot |
| reqArg | input | 3xDATA_W | Operand for each slot |
| respValid | output | 1 | Result of the previous cycle's request |
| respData | output | DATA_W | Slot 0 value before its update |
| queueFull | output | 1 | Pending queue holds QDEPTH commands |
| dropCount | output | CNT_W | Wrapping count of discarded deferred commands |

## Verification
A queue pointer or ordering fault shows up when a register is read back after the queue has drained. With the default depth this takes at most four idle cycles, and the read returns a stale or twice-applied value. A fault in forwarding shows up in the very next `respData` after a request that queues an update to the same index. A flaw in arbitration shows up as `queueFull` clearing while requests are still arriving, or as a register changing while requests keep the port busy. Drop accounting is checked by filling the queue and reading `dropCount` one cycle later.

// File: rtl/rmw_array_pkg.sv
package rmw_array_pkg;
  parameter int IDX_W  = 5;
  parameter int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_READ = 2'd1,
    OP_ADD  = 2'd2,
    OP_SET  = 2'd3
  } rmwOp_e;

  typedef struct packed {
    rmwOp_e              op;
    logic [IDX_W-1:0]    idx;
    logic [DATA_W-1:0]   arg;
  } rmwCmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                wrEn;
    logic [IDX_W-1:0]    wrIdx;
    logic [DATA_W-1:0]   wrData;
    logic                respLoad;
    logic [DATA_W-1:0]   respData;
  } memStrobe_t;

  function automatic logic [DATA_W-1:0] applyOp(rmwOp_e op,
                                                logic [DATA_W-1:0] cur,
                                                logic [DATA_W-1:0] arg);
    case (op)
      OP_ADD:  applyOp = cur + arg;
      OP_SET:  applyOp = arg;
      default: applyOp = cur;
    endcase
  endfunction
endpackage

// File: rtl/rmw_array_datapath.sv
module rmw_array_datapath
  import rmw_array_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdIdx,
  input  memStrobe_t        strb,
  output logic [DATA_W-1:0] rdData,
  output logic              respValid,
  output logic [DATA_W-1:0] respData
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rdData = mem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      if (strb.wrEn) mem[strb.wrIdx] <= strb.wrData;
      respValid <= strb.respLoad;
      if (strb.respLoad) respData <= strb.respData;
    end
  end

  AST_RESP_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.respLoad |=> respValid);                                   // R3
  AST_RESP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.respLoad |=> !respValid);                                 // R3
endmodule

// File: rtl/rmw_array_ctrl.sv
module rmw_array_ctrl
  import rmw_array_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  rmwCmd_t [2:0]     cmd,
  input  logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  rdIdx,
  output memStrobe_t        strb,
  output logic              queueFull,
  output logic [CNT_W-1:0]  dropCount
);
  localparam int CW = $clog2(QDEPTH + 1);

  rmwCmd_t          q     [QDEPTH];
  rmwCmd_t          qNext [QDEPTH];
  logic [CW-1:0]    count, cntNext, space, slot2Pos;
  logic [DATA_W-1:0] fwd;
  logic             want1, want2, take1, take2;
  logic [1:0]       dropN;
  rmwCmd_t          head;

  assign head      = q[0];
  assign queueFull = (count == CW'(QDEPTH));
  assign rdIdx     = reqValid ? cmd[0].idx : head.idx;

  // forward every pending update aimed at the immediate index, oldest first
  always_comb begin
    fwd = rdData;
    for (int i = 0; i < QDEPTH; i++) begin
      if (CW'(i) < count && q[i].op != OP_NOP && q[i].idx == cmd[0].idx)
        fwd = applyOp(q[i].op, fwd, q[i].arg);
    end
  end

  always_comb begin
    strb = '0;
    if (reqValid) begin
      strb.wrEn     = (cmd[0].op != OP_NOP);
      strb.wrIdx    = cmd[0].idx;
      strb.wrData   = applyOp(cmd[0].op, fwd, cmd[0].arg);
      strb.respLoad = 1'b1;
      strb.respData = fwd;
    end else begin
      strb.wrEn     = (count != '0) && (head.op != OP_NOP);
      strb.wrIdx    = head.idx;
      strb.wrData   = applyOp(head.op, rdData, head.arg);
    end
  end

  always_comb begin
    space    = CW'(QDEPTH) - count;
    want1    = reqValid && (cmd[1].op != OP_NOP);
    want2    = reqValid && (cmd[2].op != OP_NOP);
    take1    = want1 && (space >= CW'(1));
    take2    = want2 && (space >= (take1 ? CW'(2) : CW'(1)));
    dropN    = {1'b0, want1 && !take1} + {1'b0, want2 && !take2};
    slot2Pos = count + CW'(take1);
  end

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) qNext[i] = q[i];
    cntNext = count;
    if (reqValid) begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (cmd[0].op != OP_NOP && CW'(i) < count && q[i].idx == cmd[0].idx)
          qNext[i].op = OP_NOP;               // absorbed by the immediate write
        if (take1 && CW'(i) == count)    qNext[i] = cmd[1];
        if (take2 && CW'(i) == slot2Pos) qNext[i] = cmd[2];
      end
      cntNext = count + CW'(take1) + CW'(take2);
    end else if (count != '0) begin
      for (int i = 0; i < QDEPTH - 1; i++) qNext[i] = q[i+1];
      qNext[QDEPTH-1] = '0;
      cntNext = count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
      count     <= '0;
      dropCount <= '0;
    end else begin
      for (int i = 0; i < QDEPTH; i++) q[i] <= qNext[i];
      count     <= cntNext;
      dropCount <= dropCount + CNT_W'(dropN);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(QDEPTH));                                          // R7
  AST_IMM_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> count >= $past(count));                            // R5
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && count != '0) |=> count == $past(count) - CW'(1)); // R5
  AST_DROP_ONLY_NEAR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |->
      ($past(reqValid) && $past(count) >= CW'(QDEPTH - 1)));        // R7
endmodule

// File: rtl/rmw_array.sv
module rmw_array
  import rmw_array_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [2:0][1:0]        reqOp,
  input  logic [2:0][IDX_W-1:0]  reqIdx,
  input  logic [2:0][DATA_W-1:0] reqArg,
  output logic                   respValid,
  output logic [DATA_W-1:0]      respData,
  output logic                   queueFull,
  output logic [CNT_W-1:0]       dropCount
);
  rmwCmd_t [2:0]     cmd;
  memStrobe_t        strb;
  logic [IDX_W-1:0]  rdIdx;
  logic [DATA_W-1:0] rdData;

  for (genvar g = 0; g < 3; g++) begin : g_slot
    assign cmd[g].op  = rmwOp_e'(reqOp[g]);
    assign cmd[g].idx = reqIdx[g];
    assign cmd[g].arg = reqArg[g];
  end

  rmw_array_ctrl #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cmd(cmd),
    .rdData(rdData), .rdIdx(rdIdx), .strb(strb),
    .queueFull(queueFull), .dropCount(dropCount)
  );

  rmw_array_datapath u_dp (
    .clk(clk), .rstN(rstN), .rdIdx(rdIdx), .strb(strb),
    .rdData(rdData), .respValid(respValid), .respData(respData)
  );
endmodule

// File: tb/rmw_array_bench.sv
module rmw_array_bench;
  import rmw_array_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic                   reqValid;
  logic [2:0][1:0]        reqOp;
  logic [2:0][IDX_W-1:0]  reqIdx;
  logic [2:0][DATA_W-1:0] reqArg;
  logic                   respValid;
  logic [DATA_W-1:0]      respData;
  logic                   queueFull;
  logic [7:0]             dropCount;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic             lastValid;
  logic [DATA_W-1:0] lastData;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmw_array u_rmw_array (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIdx(reqIdx), .reqArg(reqArg), .respValid(respValid),
    .respData(respData), .queueFull(queueFull), .dropCount(dropCount)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one request for one cycle, sample its response at the next negedge
  task automatic doReq(input logic [1:0] o0, input int i0, input longint a0,
                       input logic [1:0] o1, input int i1, input longint a1,
                       input logic [1:0] o2, input int i2, input longint a2);
    reqValid  = 1'b1;
    reqOp[0]  = o0; reqIdx[0] = IDX_W'(i0); reqArg[0] = DATA_W'(a0);
    reqOp[1]  = o1; reqIdx[1] = IDX_W'(i1); reqArg[1] = DATA_W'(a1);
    reqOp[2]  = o2; reqIdx[2] = IDX_W'(i2); reqArg[2] = DATA_W'(a2);
    @(negedge clk);
    lastValid = respValid;
    lastData  = respData;
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    reqOp    = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg(input int idx, output logic [DATA_W-1:0] val);
    doReq(2'd1, idx, 0, 2'd0, 0, 0, 2'd0, 0, 0);
    val = lastData;
    idle(0);
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] v;
    check("R1 respValid", respValid, 0);
    check("R1 queueFull", queueFull, 0);
    check("R1 dropCount", dropCount, 0);
    readReg(5, v);
    check("R1 reg5", v, 0);
  endtask

  task automatic t_immediate();
    logic [DATA_W-1:0] v;
    doReq(2'd3, 3, 100, 2'd0, 0, 0, 2'd0, 0, 0);
    check("R3 valid", lastValid, 1);
    check("R3 old value", lastData, 0);
    idle(1);
    check("R3 no valid when idle", respValid, 0);
    readReg(3, v);
    check("R2 set", v, 100);
    doReq(2'd2, 3, 5, 2'd0, 0, 0, 2'd0, 0, 0);
    check("R3 pre-add value", lastData, 100);
    idle(0);
    readReg(3, v);
    check("R2 add", v, 105);
    doReq(2'd3, 30, 64'hFFFF_FFFF, 2'd0, 0, 0, 2'd0, 0, 0);
    doReq(2'd2, 30, 2, 2'd0, 0, 0, 2'd0, 0, 0);
    idle(0);
    readReg(30, v);
    check("R2 wrap", v, 1);
  endtask

  task automatic t_deferred();
    logic [DATA_W-1:0] v;
    doReq(2'd1, 7, 0, 2'd3, 8, 42, 2'd2, 8, 1);
    idle(2);
    check("R8 queue empty", queueFull, 0);
    readReg(8, v);
    check("R8 all three applied", v, 43);
  endtask

  task automatic t_nop();
    for (int k = 0; k < 3; k++) doReq(2'd1, 0, 0, 2'd0, 9, 1, 2'd0, 9, 1);
    check("R4 nop takes no space", queueFull, 0);
    check("R4 nop never dropped", dropCount, 0);
    idle(1);
  endtask

  task automatic t_forward();
    logic [DATA_W-1:0] v;
    doReq(2'd1, 9, 0, 2'd2, 10, 7, 2'd0, 0, 0);
    doReq(2'd2, 10, 1, 2'd0, 0, 0, 2'd0, 0, 0);
    check("R6 forwarded pending add", lastData, 7);
    idle(3);
    readReg(10, v);
    check("R6 no double apply", v, 8);
    doReq(2'd1, 12, 0, 2'd3, 11, 5, 2'd2, 11, 3);
    doReq(2'd1, 11, 0, 2'd0, 0, 0, 2'd0, 0, 0);
    check("R4 slot order", lastData, 8);
    idle(3);
    readReg(11, v);
    check("R6 read absorbs cleanly", v, 8);
  endtask

  task automatic t_full();
    logic [DATA_W-1:0] v;
    doReq(2'd1, 20, 0, 2'd3, 21, 1, 2'd3, 22, 2);
    doReq(2'd1, 20, 0, 2'd3, 23, 3, 2'd3, 24, 4);
    check("R7 full after four", queueFull, 1);
    check("R7 no drop yet", dropCount, 0);
    doReq(2'd3, 20, 9, 2'd3, 25, 5, 2'd3, 26, 6);
    check("R5 immediate served while full", lastData, 0);
    check("R7 two dropped", dropCount, 2);
    doReq(2'd1, 20, 0, 2'd0, 0, 0, 2'd0, 0, 0);
    check("R5 immediate result", lastData, 9);
    check("R5 no drain under requests", queueFull, 1);
    idle(4);
    check("R5 drained in idle", queueFull, 0);
    readReg(21, v); check("R5 q21", v, 1);
    readReg(22, v); check("R5 q22", v, 2);
    readReg(23, v); check("R5 q23", v, 3);
    readReg(24, v); check("R5 q24", v, 4);
    readReg(25, v); check("R7 dropped 25", v, 0);
    readReg(26, v); check("R7 dropped 26", v, 0);
  endtask

  initial begin
    rstN = 1'b0;
    reqValid = 1'b0;
    reqOp = '0; reqIdx = '0; reqArg = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_deferred();
    t_nop();
    t_forward();
    t_full();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule